// File: doc/BRIEF.md
# T1/E1 Per-Timeslot Strobe Generator

This block produces the per-timeslot timing strobes for one T1 or E1 transmit port. A bit counter follows the transmit bit clock. A frame-sync pulse aligns it, and it wraps by itself at the end of each frame when no sync comes. From the bit position the block derives two outputs. The first is a block level, set high or low for each timeslot from a bitmap. The second is a channel clock that runs in one of two modes. In gapped mode it lets clock pulses through only for enabled timeslots, which gives an N x 64 kHz fractional clock; in T1 the framing bit can be let through as well. In pulse mode it goes high for one bit at the end of every timeslot.

Software loads the slot-enable bitmap, the block-level bitmap and a control word through a write-only port. The block keeps these values as staged copies. It moves them into its working set only at the start of a frame, together with the T1/E1 select pin. A serial controller or a drop-and-insert path downstream therefore never sees a frame with mixed settings. All outputs follow the clock that feeds the block. The integrator chooses whether that is the line transmit clock or a system clock.

Top module: `chan_timing_gen`

## Requirements
- R1: The frame is 193 bit positions in T1 and 256 in E1. In T1, position 0 is the framing bit and position 1+8t+b is bit b of timeslot t. In E1, position 8t+b is bit b of timeslot t. Bit b=0 is the MSB and b=7 is the LSB. If `frame_sync` is high at a rising clock edge, that edge starts position 0. Otherwise the position advances by one per edge and wraps to 0 after the last position.
- R2: `ch_block` equals bit t of the block-level bitmap during all eight bits of timeslot t. It is low during the T1 framing bit.
- R3: In gapped mode (control bit 0 = 0), `ch_clock` carries one high pulse for each bit of a timeslot t whose slot-enable bit t is 1. The pulse is the clock-high phase that begins at the rising edge ending that bit. At all other times `ch_clock` is low, including the whole clock-low phase. The T1 framing bit gets a pulse only when control bit 1 is 1. Control bit 1 has no effect in E1.
- R4: In pulse mode (control bit 0 = 1), `ch_clock` is high for the whole LSB bit period of every timeslot and low otherwise. This gives 24 pulses per T1 frame and 32 per E1 frame, whatever the slot-enable bitmap and control bit 1 hold.
- R5: A write sets one staged register selected by `reg_addr`: 0 = slot-enable bitmap, 1 = block-level bitmap, 2 = control. A write to address 3 changes nothing.
- R6: Staged registers and the `e1_sel` pin take effect at the first frame start after the write edge. The frame in progress keeps its settings, including its length.
- R7: While `rst_n` is low, both outputs are low and all registers are clear (T1, gapped, nothing enabled, all levels low). The first rising edge after reset is released begins position 0 of a frame.
- R8: In T1, bitmap bits 24 to 31 have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (line transmit or system clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | High at an edge: that edge starts frame position 0 |
| e1_sel | input | 1 | 1 = E1 framing, 0 = T1; taken at frame start |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Staged register select |
| reg_wdata | input | 32 | Write data; bit t maps to timeslot t |
| ch_block | output | 1 | Per-timeslot programmable level |
| ch_clock | output | 1 | Gapped fractional clock or per-timeslot LSB pulse |

## Verification
The bench uses the default parameters: 8-bit timeslots, 24 T1 slots and 32 E1 slots. This gives the standard 193-bit and 256-bit frames, so the framing bit, timeslots 0, 23 and 31 and the unused T1 bitmap bits 24 to 31 are all exercised. Every bit position of each frame is compared against a model of the two output levels. The clock output is checked in both clock phases. In some tests the frame runs on with no sync, so an off-by-one frame length would shift every later comparison. Mid-frame register writes and a mid-frame change of the T1/E1 pin are followed into the next frame to show the staged update.

// File: rtl/ctg_pkg.sv
`timescale 1ns/1ps
package ctg_pkg;

    typedef enum logic [1:0] {
        REG_SLOT_EN  = 2'd0,
        REG_SLOT_LVL = 2'd1,
        REG_CTRL     = 2'd2,
        REG_SPARE    = 2'd3
    } reg_sel_e;

    localparam int CTRL_PULSE_MODE = 0;
    localparam int CTRL_FRAME_BIT  = 1;

    typedef struct packed {
        logic lvl;
        logic gate;
        logic pulse;
        logic pulse_mode;
    } strobe_t;

endpackage

// File: rtl/ctg_bit_counter.sv
`timescale 1ns/1ps
module ctg_bit_counter #(
    parameter int T1_LEN = 193,
    parameter int E1_LEN = 256,
    parameter int CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sync,
    input  logic             e1_act,
    output logic [CNT_W-1:0] pos_q,
    output logic [CNT_W-1:0] pos_d,
    output logic             frame_start
);

    typedef struct packed {
        logic [CNT_W-1:0] pos;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W-1:0] last_pos;

    always_comb begin
        st_d     = st_q;
        last_pos = e1_act ? CNT_W'(E1_LEN - 1) : CNT_W'(T1_LEN - 1);
        if (frame_sync || (st_q.pos >= last_pos)) begin
            st_d.pos = '0;
        end else begin
            st_d.pos = st_q.pos + CNT_W'(1);
        end
    end

    // reset value sits at or beyond the last position, so the first edge starts bit 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pos <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_q       = st_q.pos;
    assign pos_d       = st_d.pos;
    assign frame_start = (st_d.pos == '0);

    a_r1_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (pos_q == '0));

    a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_sync && (pos_q < last_pos)) |=> (pos_q == $past(pos_q) + CNT_W'(1)));

endmodule

// File: rtl/ctg_cfg_regs.sv
`timescale 1ns/1ps
module ctg_cfg_regs
    import ctg_pkg::*;
#(
    parameter int MAP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [MAP_W-1:0] wr_data,
    input  logic             e1_pin,
    input  logic             frame_start,
    output logic [MAP_W-1:0] nxt_en,
    output logic [MAP_W-1:0] nxt_lvl,
    output logic             nxt_pulse_mode,
    output logic             nxt_fbit,
    output logic             nxt_e1,
    output logic             act_e1
);

    typedef struct packed {
        logic [MAP_W-1:0] en;
        logic [MAP_W-1:0] lvl;
        logic             pulse_mode;
        logic             fbit;
    } map_t;

    typedef struct packed {
        map_t shd;
        map_t act;
        logic act_e1;
    } reg_st_t;

    reg_st_t st_d, st_q;
    map_t    sel;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                REG_SLOT_EN:  st_d.shd.en  = wr_data;
                REG_SLOT_LVL: st_d.shd.lvl = wr_data;
                REG_CTRL: begin
                    st_d.shd.pulse_mode = wr_data[CTRL_PULSE_MODE];
                    st_d.shd.fbit       = wr_data[CTRL_FRAME_BIT];
                end
                default: ;
            endcase
        end
        if (frame_start) begin
            st_d.act    = st_q.shd;
            st_d.act_e1 = e1_pin;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // settings that govern the position produced by this edge
    always_comb begin
        sel    = frame_start ? st_q.shd : st_q.act;
        nxt_e1 = frame_start ? e1_pin   : st_q.act_e1;
    end

    assign nxt_en         = sel.en;
    assign nxt_lvl        = sel.lvl;
    assign nxt_pulse_mode = sel.pulse_mode;
    assign nxt_fbit       = sel.fbit;
    assign act_e1         = st_q.act_e1;

    a_r6_hold_within_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(st_q.act) && $stable(st_q.act_e1)));

    a_r5_spare_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == 2'd3)) |=> $stable(st_q.shd));

endmodule

// File: rtl/ctg_slot_decode.sv
`timescale 1ns/1ps
module ctg_slot_decode #(
    parameter int SLOT_BITS = 8,
    parameter int MAP_W     = 32,
    parameter int CNT_W     = 8
) (
    input  logic [CNT_W-1:0] pos,
    input  logic             e1,
    input  logic [MAP_W-1:0] en,
    input  logic [MAP_W-1:0] lvl,
    input  logic             fbit_en,
    output logic             gate,
    output logic             level,
    output logic             last_bit
);

    localparam int SB_W = $clog2(SLOT_BITS);
    localparam int TS_W = CNT_W - SB_W;

    logic             on_fbit;
    logic [CNT_W-1:0] rel;
    logic [TS_W-1:0]  ts;
    logic [SB_W-1:0]  bidx;

    always_comb begin
        on_fbit  = !e1 && (pos == '0);
        rel      = e1 ? pos : (pos - CNT_W'(1));
        ts       = rel[CNT_W-1:SB_W];
        bidx     = rel[SB_W-1:0];
        gate     = on_fbit ? fbit_en : en[ts];
        level    = on_fbit ? 1'b0    : lvl[ts];
        last_bit = !on_fbit && (bidx == SB_W'(SLOT_BITS - 1));
    end

endmodule

// File: rtl/chan_timing_gen.sv
`timescale 1ns/1ps
module chan_timing_gen
    import ctg_pkg::*;
#(
    parameter int SLOT_BITS = 8,
    parameter int T1_SLOTS  = 24,
    parameter int E1_SLOTS  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_sync,
    input  logic                e1_sel,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [E1_SLOTS-1:0] reg_wdata,
    output logic                ch_block,
    output logic                ch_clock
);

    localparam int T1_LEN = 1 + T1_SLOTS * SLOT_BITS;
    localparam int E1_LEN = E1_SLOTS * SLOT_BITS;
    localparam int CNT_W  = $clog2(E1_LEN);
    localparam int SB_W   = $clog2(SLOT_BITS);

    logic [CNT_W-1:0]    pos_q, pos_d;
    logic                frame_start;
    logic                act_e1;
    logic [E1_SLOTS-1:0] nxt_en, nxt_lvl;
    logic                nxt_pulse_mode, nxt_fbit, nxt_e1;
    logic                dec_gate, dec_level, dec_last;

    strobe_t out_d, out_q;
    logic    gate_n_q;

    ctg_bit_counter #(
        .T1_LEN (T1_LEN),
        .E1_LEN (E1_LEN),
        .CNT_W  (CNT_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_sync  (frame_sync),
        .e1_act      (act_e1),
        .pos_q       (pos_q),
        .pos_d       (pos_d),
        .frame_start (frame_start)
    );

    ctg_cfg_regs #(
        .MAP_W (E1_SLOTS)
    ) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (reg_wr),
        .wr_addr        (reg_addr),
        .wr_data        (reg_wdata),
        .e1_pin         (e1_sel),
        .frame_start    (frame_start),
        .nxt_en         (nxt_en),
        .nxt_lvl        (nxt_lvl),
        .nxt_pulse_mode (nxt_pulse_mode),
        .nxt_fbit       (nxt_fbit),
        .nxt_e1         (nxt_e1),
        .act_e1         (act_e1)
    );

    ctg_slot_decode #(
        .SLOT_BITS (SLOT_BITS),
        .MAP_W     (E1_SLOTS),
        .CNT_W     (CNT_W)
    ) u_dec (
        .pos      (pos_d),
        .e1       (nxt_e1),
        .en       (nxt_en),
        .lvl      (nxt_lvl),
        .fbit_en  (nxt_fbit),
        .gate     (dec_gate),
        .level    (dec_level),
        .last_bit (dec_last)
    );

    always_comb begin
        out_d            = out_q;
        out_d.lvl        = dec_level;
        out_d.gate       = dec_gate && !nxt_pulse_mode;
        out_d.pulse      = dec_last && nxt_pulse_mode;
        out_d.pulse_mode = nxt_pulse_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    // enable retimed on the falling edge: stable for the whole following high phase
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_n_q <= 1'b0;
        end else begin
            gate_n_q <= out_q.gate;
        end
    end

    assign ch_block = out_q.lvl;
    assign ch_clock = out_q.pulse_mode ? out_q.pulse : (clk & gate_n_q);

    a_r2_fbit_level_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_e1 && (pos_q == '0)) |-> !out_q.lvl);

    a_r4_single_bit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.pulse |=> !out_q.pulse);

    a_r4_pulse_on_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.pulse |-> (act_e1 ? (pos_q[SB_W-1:0] == SB_W'(SLOT_BITS - 1))
                                : ((pos_q != '0) && (pos_q[SB_W-1:0] == '0))));

    a_r3_no_gate_in_pulse_mode: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.pulse_mode |-> !out_q.gate);

endmodule

// File: tb/tb_chan_timing_gen.sv
`timescale 1ns/1ps
module tb_chan_timing_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_sync = 1'b0;
    logic        e1_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic        ch_block;
    logic        ch_clock;

    int n_tests = 0;
    int n_fail  = 0;
    bit last_valid = 1'b0;
    bit last_gate  = 1'b0;

    always #5 clk = ~clk;

    chan_timing_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .e1_sel     (e1_sel),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .ch_block   (ch_block),
        .ch_clock   (ch_clock)
    );

    function automatic bit exp_lvl(bit e1, logic [31:0] lvl, int p);
        if (!e1) return (p == 0) ? 1'b0 : lvl[(p - 1) / 8];
        return lvl[p / 8];
    endfunction

    function automatic bit exp_gate(bit e1, bit cm, bit fb, logic [31:0] en, int p);
        if (cm) return 1'b0;
        if (!e1) return (p == 0) ? fb : en[(p - 1) / 8];
        return en[p / 8];
    endfunction

    function automatic bit exp_pulse(bit e1, bit cm, int p);
        if (!cm) return 1'b0;
        if (!e1) return (p != 0) && (((p - 1) % 8) == 7);
        return (p % 8) == 7;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // entered and left in the clock-low phase
    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        #2;
        last_valid = 1'b0;
    endtask

    task automatic run_frame(string tag_lvl, string tag_clk, bit e1, bit cm, bit fb,
                             logic [31:0] en, logic [31:0] lvl, bit use_sync, int nbits,
                             bit mid_wr, logic [1:0] mid_addr, logic [31:0] mid_data,
                             bit mid_e1, bit mid_e1_val);
        int len = e1 ? 256 : 193;
        int n = (nbits > 0) ? nbits : len;
        int bad_l = 0, bad_c = 0, npul = 0;
        int fp_l = -1, fa_l = 0, fe_l = 0, fp_c = -1, fa_c = 0, fe_c = 0;
        if (use_sync) frame_sync = 1'b1;
        for (int p = 0; p < n; p++) begin
            bit el, ec, check_c;
            @(posedge clk);
            #2;
            el = exp_lvl(e1, lvl, p);
            check_c = 1'b1;
            if (cm) ec = exp_pulse(e1, cm, p);
            else if (p == 0) begin ec = last_gate; check_c = last_valid; end
            else ec = exp_gate(e1, cm, fb, en, p - 1);
            if (ch_block !== el) begin
                bad_l++;
                if (fp_l < 0) begin fp_l = p; fa_l = int'(ch_block); fe_l = int'(el); end
            end
            if (check_c && (ch_clock !== ec)) begin
                bad_c++;
                if (fp_c < 0) begin fp_c = p; fa_c = int'(ch_clock); fe_c = int'(ec); end
            end
            if (cm && ch_clock === 1'b1) npul++;
            @(negedge clk);
            frame_sync = 1'b0;
            reg_wr = 1'b0;
            if (mid_wr && p == 100) begin
                reg_wr = 1'b1; reg_addr = mid_addr; reg_wdata = mid_data;
            end
            if (mid_e1 && p == 100) e1_sel = mid_e1_val;
            #2;
            ec = exp_pulse(e1, cm, p);
            if (ch_clock !== ec) begin
                bad_c++;
                if (fp_c < 0) begin fp_c = p; fa_c = int'(ch_clock); fe_c = int'(ec); end
            end
        end
        last_gate  = exp_gate(e1, cm, fb, en, n - 1);
        last_valid = 1'b1;
        n_tests++;
        if (bad_l != 0) begin
            n_fail++;
            $display("FAIL %s ch_block: %0d mismatches, first at bit %0d: actual=%0d expected=%0d",
                     tag_lvl, bad_l, fp_l, fa_l, fe_l);
        end
        n_tests++;
        if (bad_c != 0) begin
            n_fail++;
            $display("FAIL %s ch_clock: %0d mismatches, first at bit %0d: actual=%0d expected=%0d",
                     tag_clk, bad_c, fp_c, fa_c, fe_c);
        end
        if (cm && n == len) chk(tag_clk, "LSB pulses per frame", npul, e1 ? 32 : 24);
    endtask

    // R7: outputs low in reset; first edge after release is frame bit 0
    task automatic t_reset;
        int bad = 0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #2;
            if (ch_block !== 1'b0 || ch_clock !== 1'b0) bad++;
            @(negedge clk); #2;
            if (ch_block !== 1'b0 || ch_clock !== 1'b0) bad++;
        end
        chk("R7", "outputs high during reset", bad, 0);
        rst_n = 1'b1;
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd2, 32'h0000_0002);
        bad = 0;
        for (int p = 3; p < 193; p++) begin
            @(posedge clk); #2;
            if (ch_block !== 1'b0 || ch_clock !== 1'b0) bad++;
            @(negedge clk); #2;
        end
        chk("R7", "cleared settings used in first frame", bad, 0);
        last_gate = 1'b0; last_valid = 1'b1;
        run_frame("R7", "R7", 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                  1'b0, 0, 1'b0, 2'd0, '0, 1'b0, 1'b0);
    endtask

    task automatic t_t1_gapped;
        e1_sel = 1'b0;
        wr(2'd0, 32'h00A5_0F01);
        wr(2'd1, 32'h00C3_5A81);
        wr(2'd2, 32'h0000_0002);
        run_frame("R2", "R3", 1'b0, 1'b0, 1'b1, 32'h00A5_0F01, 32'h00C3_5A81,
                  1'b1, 0, 1'b0, 2'd0, '0, 1'b0, 1'b0);
    endtask

    task automatic t_t1_upper_bits;
        wr(2'd0, 32'hFF80_0001);
        wr(2'd1, 32'hFF00_0002);
        wr(2'd2, 32'h0000_0000);
        run_frame("R8", "R8", 1'b0, 1'b0, 1'b0, 32'hFF80_0001, 32'hFF00_0002,
                  1'b1, 0, 1'b0, 2'd0, '0, 1'b0, 1'b0);
    endtask

    task automatic t_e1_gapped;
        e1_sel = 1'b1;
        wr(2'd0, 32'h8001_0001);
        wr(2'd1, 32'h8000_0001);
        wr(2'd2, 32'h0000_0002);
        run_frame("R1", "R3", 1'b1, 1'b0, 1'b1, 32'h8001_0001, 32'h8000_0001,
                  1'b1, 0, 1'b0, 2'd0, '0, 1'b0, 1'b0);
    endtask

    task automatic t_e1_pulse;
        e1_sel = 1'b1;
        wr(2'd0, 32'h0000_0000);
        wr(2'd1, 32'h5555_AAAA);
        wr(2'd2, 32'h0000_0001);
        run_frame("R2", "R4", 1'b1, 1'b1, 1'b0, 32'h0, 32'h5555_AAAA,
                  1'b1, 0, 1'b0, 2'd0, '0, 1'b0, 1'b0);
    endtask

    task automatic t_t1_pulse;
        e1_sel = 1'b0;
        wr(2'd0, 32'h0F0F_0F0F);
        wr(2'd2, 32'h0000_0003);
        run_frame("R2", "R4", 1'b0, 1'b1, 1'b1, 32'h0F0F_0F0F, 32'h5555_AAAA,
                  1'b1, 0, 1'b0, 2'd0, '0, 1'b0, 1'b0);
    endtask

    task automatic t_sync_restart;
        e1_sel = 1'b0;
        wr(2'd0, 32'h00F0_0F0F);
        wr(2'd1, 32'h0012_3456);
        wr(2'd2, 32'h0000_0002);
        run_frame("R1", "R1", 1'b0, 1'b0, 1'b1, 32'h00F0_0F0F, 32'h0012_3456,
                  1'b1, 77, 1'b0, 2'd0, '0, 1'b0, 1'b0);
        run_frame("R1", "R1", 1'b0, 1'b0, 1'b1, 32'h00F0_0F0F, 32'h0012_3456,
                  1'b1, 0, 1'b0, 2'd0, '0, 1'b0, 1'b0);
    endtask

    task automatic t_staging;
        run_frame("R6", "R6", 1'b0, 1'b0, 1'b1, 32'h00F0_0F0F, 32'h0012_3456,
                  1'b1, 0, 1'b1, 2'd1, 32'h00ED_CBA9, 1'b0, 1'b0);
        run_frame("R6", "R1", 1'b0, 1'b0, 1'b1, 32'h00F0_0F0F, 32'h00ED_CBA9,
                  1'b0, 0, 1'b1, 2'd0, 32'h0000_FF00, 1'b0, 1'b0);
        run_frame("R6", "R6", 1'b0, 1'b0, 1'b1, 32'h0000_FF00, 32'h00ED_CBA9,
                  1'b0, 0, 1'b0, 2'd0, '0, 1'b0, 1'b0);
    endtask

    task automatic t_mode_pin_staging;
        wr(2'd1, 32'hC000_0003);
        wr(2'd0, 32'h8000_0101);
        run_frame("R6", "R6", 1'b0, 1'b0, 1'b1, 32'h8000_0101, 32'hC000_0003,
                  1'b1, 0, 1'b0, 2'd0, '0, 1'b1, 1'b1);
        run_frame("R6", "R1", 1'b1, 1'b0, 1'b1, 32'h8000_0101, 32'hC000_0003,
                  1'b0, 0, 1'b0, 2'd0, '0, 1'b0, 1'b0);
    endtask

    task automatic t_spare_addr;
        wr(2'd3, 32'hFFFF_FFFF);
        run_frame("R5", "R5", 1'b1, 1'b0, 1'b1, 32'h8000_0101, 32'hC000_0003,
                  1'b1, 0, 1'b0, 2'd0, '0, 1'b0, 1'b0);
    endtask

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); #2;
        t_reset();
        t_t1_gapped();
        t_t1_upper_bits();
        t_e1_gapped();
        t_e1_pulse();
        t_t1_pulse();
        t_sync_restart();
        t_staging();
        t_mode_pin_staging();
        t_spare_addr();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule